// File: doc/BRIEF.md
# Level-0 Translation Walk Stage with Fault Syndrome

This block carries out the first step of a page-table walk for a 48-bit virtual address space with a 4 KB granule. A requester hands it a 64-bit virtual address and a flag telling whether the access is a store. The block looks at the sixteen address bits above bit 47. When they are all zero, the low-half translation base register is used. When they are all one, the high-half base register is used. Any other pattern is refused at once.

For a legal address, the block builds the address of the level-0 descriptor. It takes the selected base with its page offset cleared and appends the nine-bit index from address bits 47..39, scaled by eight bytes. It issues one read on a simple request/response port and waits for the descriptor.

A descriptor whose two low bits are both set points to a next-level table, and that table address is handed onward. Any other descriptor, and any refused address, ends the walk with a data abort. The abort reports an encoded syndrome word and the full faulting address. Each walk ends with a single-cycle completion pulse. While a walk is in progress the block takes no new request.

Top module: `l0_walk_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `ok`, `abort` and `mem_req` are all 0.
- R2: A request is accepted on a clock edge where `req_valid` is 1 and `busy` is 0. If `req_va[63:48]` is 0x0000, `base_lo` is selected; if it is 0xFFFF, `base_hi` is selected. The descriptor read address is `{base[47:12], req_va[47:39], 3'b000}`.
- R3: For a legal address, `mem_req` is 1 for exactly one cycle, in the cycle right after acceptance, and stays 0 for the rest of that walk.
- R4: If `req_va[63:48]` is neither 0x0000 nor 0xFFFF, no read is issued. `done` and `abort` are 1 in the cycle right after acceptance.
- R5: A descriptor with bits [1:0] = 2'b11 completes the walk with `ok`=1 and `abort`=0. `next_table` is then `{desc[47:12], 12'h000}`.
- R6: A descriptor with bits [1:0] equal to 2'b00, 2'b01 or 2'b10 completes the walk with `abort`=1 and `ok`=0.
- R7: On an abort, `syndrome` has bits [31:26] = 6'b100101 and bit 25 = 1. Bit 6 equals the store flag, bits [5:0] = 6'b000100, and every other bit is 0. A store therefore reads 0x96000044 and a load reads 0x96000004.
- R8: On an abort, `fault_addr` equals the complete 64-bit virtual address of the faulting request.
- R9: `req_valid` is ignored while `busy` is 1. The walk in progress keeps its own address and store flag.
- R10: `mem_rvalid` is ignored unless a read is outstanding: it produces no `done` pulse.
- R11: `done` is a single-cycle pulse, and `done` is 1 exactly when one of `ok` or `abort` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk |
| req_va | input | 64 | Virtual address to translate |
| req_write | input | 1 | 1 for a store access, 0 for a load |
| base_lo | input | 64 | Translation base for the low address half |
| base_hi | input | 64 | Translation base for the high address half |
| mem_req | output | 1 | Descriptor read request (one-cycle pulse) |
| mem_addr | output | 48 | Descriptor byte address |
| mem_rvalid | input | 1 | Descriptor data returned |
| mem_rdata | input | 64 | Descriptor contents |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk complete (one-cycle pulse) |
| ok | output | 1 | Walk found a next-level table |
| abort | output | 1 | Walk ended in a level-0 translation fault |
| next_table | output | 48 | Next-level table address, valid with ok |
| syndrome | output | 32 | Encoded abort syndrome, valid with abort |
| fault_addr | output | 64 | Faulting virtual address, valid with abort |

## Verification
Addresses are drawn from three classes: all-zero upper bits, all-one upper bits, and mixed upper bits. Comparing the read address against each base register shows whether the half is chosen correctly, and the mixed class shows that refused addresses never reach memory. Descriptors are drawn with every value of the two low bits, paired with both store and load flags, so that the table case is told apart from each fault kind and the write-not-read bit of the syndrome is shown to follow the request. Directed cases cover these situations:
- a store fault in the high half with index 2;
- stray read responses while idle;
- new requests pushed in the middle of a walk, which must leave the reported fault address untouched.

// File: rtl/l0w_pkg.sv
package l0w_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } walk_state_e;

  typedef enum logic [1:0] {
    HALF_LOW  = 2'd0,
    HALF_HIGH = 2'd1,
    HALF_NONE = 2'd2
  } half_sel_e;

  localparam int unsigned SYN_BITS      = 32;
  localparam logic [5:0]  EC_DABT_SAME  = 6'b100101;
  localparam logic [5:0]  FSC_XLAT_L0   = 6'b000100;
  localparam int unsigned SYN_EC_LSB    = 26;
  localparam int unsigned SYN_IL_BIT    = 25;
  localparam int unsigned SYN_WNR_BIT   = 6;

  // Assemble the abort syndrome word from its fields.
  function automatic logic [SYN_BITS-1:0] make_syndrome(input logic wnr,
                                                         input logic [5:0] fsc);
    logic [SYN_BITS-1:0] w;
    w = '0;
    w[SYN_EC_LSB +: 6]  = EC_DABT_SAME;
    w[SYN_IL_BIT]       = 1'b1;
    w[SYN_WNR_BIT]      = wnr;
    w[5:0]              = fsc;
    return w;
  endfunction

endpackage

// File: rtl/l0w_half_select.sv
module l0w_half_select
  import l0w_pkg::*;
#(
  parameter int unsigned VA_BITS  = 48,
  parameter int unsigned REG_BITS = 64
) (
  input  logic [REG_BITS-1:VA_BITS] va_top,
  input  logic [REG_BITS-1:0]       base_lo,
  input  logic [REG_BITS-1:0]       base_hi,
  output half_sel_e                 half,
  output logic [REG_BITS-1:0]       sel_base
);
  localparam int unsigned TOP_BITS = REG_BITS - VA_BITS;

  logic all_zero;
  logic all_one;

  generate
    if (TOP_BITS > 0) begin : g_top
      assign all_zero = (va_top == '0);
      assign all_one  = (va_top == {TOP_BITS{1'b1}});
    end else begin : g_flat
      assign all_zero = 1'b1;
      assign all_one  = 1'b0;
    end
  endgenerate

  always_comb begin
    if (all_zero) begin
      half = HALF_LOW;
    end else if (all_one) begin
      half = HALF_HIGH;
    end else begin
      half = HALF_NONE;
    end
    sel_base = (half == HALF_HIGH) ? base_hi : base_lo;
  end
endmodule

// File: rtl/l0w_desc_decode.sv
module l0w_desc_decode #(
  parameter int unsigned VA_BITS    = 48,
  parameter int unsigned REG_BITS   = 64,
  parameter int unsigned GRAN_SHIFT = 12
) (
  input  logic [REG_BITS-1:0] desc,
  output logic                is_table,
  output logic [VA_BITS-1:0]  next_table
);
  // Only a descriptor tagged 2'b11 continues the walk at this level.
  assign is_table   = desc[0] & desc[1];
  assign next_table = {desc[VA_BITS-1:GRAN_SHIFT], {GRAN_SHIFT{1'b0}}};
endmodule

// File: rtl/l0w_syndrome_gen.sv
module l0w_syndrome_gen
  import l0w_pkg::*;
(
  input  logic                wnr,
  input  logic [5:0]          fsc,
  output logic [SYN_BITS-1:0] word
);
  assign word = make_syndrome(wnr, fsc);
endmodule

// File: rtl/l0_walk_unit.sv
module l0_walk_unit
  import l0w_pkg::*;
#(
  parameter int unsigned VA_BITS    = 48,
  parameter int unsigned REG_BITS   = 64,
  parameter int unsigned GRAN_SHIFT = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [REG_BITS-1:0] req_va,
  input  logic                req_write,
  input  logic [REG_BITS-1:0] base_lo,
  input  logic [REG_BITS-1:0] base_hi,
  output logic                mem_req,
  output logic [VA_BITS-1:0]  mem_addr,
  input  logic                mem_rvalid,
  input  logic [REG_BITS-1:0] mem_rdata,
  output logic                busy,
  output logic                done,
  output logic                ok,
  output logic                abort,
  output logic [VA_BITS-1:0]  next_table,
  output logic [31:0]         syndrome,
  output logic [REG_BITS-1:0] fault_addr
);
  // Entry size is 8 bytes, so one table holds 2^(GRAN_SHIFT-3) entries.
  localparam int unsigned IDX_BITS = GRAN_SHIFT - 3;
  localparam int unsigned IDX_LSB  = VA_BITS - IDX_BITS;

  walk_state_e         state;
  logic [REG_BITS-1:0] cap_va;
  logic                cap_wr;
  logic [VA_BITS-1:0]  cap_daddr;
  logic                res_ok;

  half_sel_e           half;
  logic [REG_BITS-1:0] sel_base;
  logic [VA_BITS-1:0]  daddr_w;
  logic                is_table;
  logic [VA_BITS-1:0]  next_w;
  logic                syn_wnr;
  logic [31:0]         syn_w;

  // Named events for the checker.
  logic accept;
  logic accept_bad;
  logic walk_pending;
  logic desc_arrive;

  assign accept       = req_valid && (state == ST_IDLE);
  assign accept_bad   = accept && (half == HALF_NONE);
  assign walk_pending = (state == ST_ISSUE) || (state == ST_WAIT);
  assign desc_arrive  = (state == ST_WAIT) && mem_rvalid;

  l0w_half_select #(.VA_BITS(VA_BITS), .REG_BITS(REG_BITS)) u_half (
    .va_top   (req_va[REG_BITS-1:VA_BITS]),
    .base_lo  (base_lo),
    .base_hi  (base_hi),
    .half     (half),
    .sel_base (sel_base)
  );

  assign daddr_w = {sel_base[VA_BITS-1:GRAN_SHIFT],
                    req_va[VA_BITS-1:IDX_LSB], 3'b000};

  l0w_desc_decode #(.VA_BITS(VA_BITS), .REG_BITS(REG_BITS),
                    .GRAN_SHIFT(GRAN_SHIFT)) u_desc (
    .desc       (mem_rdata),
    .is_table   (is_table),
    .next_table (next_w)
  );

  assign syn_wnr = (state == ST_IDLE) ? req_write : cap_wr;

  l0w_syndrome_gen u_syn (
    .wnr  (syn_wnr),
    .fsc  (FSC_XLAT_L0),
    .word (syn_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cap_va     <= '0;
      cap_wr     <= 1'b0;
      cap_daddr  <= '0;
      res_ok     <= 1'b0;
      next_table <= '0;
      syndrome   <= '0;
      fault_addr <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cap_va    <= req_va;
            cap_wr    <= req_write;
            cap_daddr <= daddr_w;
            if (half == HALF_NONE) begin
              res_ok     <= 1'b0;
              syndrome   <= syn_w;
              fault_addr <= req_va;
              state      <= ST_RESP;
            end else begin
              state <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: begin
          if (mem_rvalid) begin
            res_ok <= is_table;
            if (is_table) begin
              next_table <= next_w;
            end else begin
              syndrome   <= syn_w;
              fault_addr <= cap_va;
            end
            state <= ST_RESP;
          end
        end
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req  = (state == ST_ISSUE);
  assign mem_addr = cap_daddr;
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_RESP);
  assign ok       = done && res_ok;
  assign abort    = done && !res_ok;
endmodule

// File: rtl/l0w_checker.sv
module l0w_checker #(
  parameter int unsigned VA_BITS  = 48,
  parameter int unsigned REG_BITS = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mem_req,
  input logic                busy,
  input logic                done,
  input logic                ok,
  input logic                abort,
  input logic [31:0]         syndrome,
  input logic                accept_bad,
  input logic                walk_pending,
  input logic                mem_rvalid,
  input logic [REG_BITS-1:0] cap_va
);
  // R1: reset leaves the block idle
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && !mem_req));

  // R3: read request is a single-cycle pulse
  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R4: refused address completes next cycle without a read
  assert_refuse_no_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_bad |=> (done && abort && !mem_req));

  // R7: abort syndrome carries class, length bit and level-0 status
  assert_syndrome_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (syndrome[31:25] == 7'b1001011 && syndrome[5:0] == 6'b000100
               && syndrome[24:7] == '0));

  // R9: captured address is frozen while a walk is pending
  assert_hold_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    walk_pending |=> $stable(cap_va));

  // R10: stray response while idle gives no completion
  assert_stray_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mem_rvalid) |=> !done || $past(accept_bad));

  // R11: done is a pulse and exactly one outcome flag goes with it
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_outcome_one_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done == $onehot({ok, abort}));
endmodule

bind l0_walk_unit l0w_checker #(.VA_BITS(VA_BITS), .REG_BITS(REG_BITS)) u_l0w_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_req      (mem_req),
  .busy         (busy),
  .done         (done),
  .ok           (ok),
  .abort        (abort),
  .syndrome     (syndrome),
  .accept_bad   (accept_bad),
  .walk_pending (walk_pending),
  .mem_rvalid   (mem_rvalid),
  .cap_va       (cap_va)
);

// File: tb/l0_walk_unit_test.sv
module l0_walk_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_va = '0;
  logic        req_write = 1'b0;
  logic [63:0] base_lo = '0;
  logic [63:0] base_hi = '0;
  logic        mem_req;
  logic [47:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        busy, done, ok, abort;
  logic [47:0] next_table;
  logic [31:0] syndrome;
  logic [63:0] fault_addr;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;  // 50 MHz

  l0_walk_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_write(req_write), .base_lo(base_lo), .base_hi(base_hi),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .ok(ok), .abort(abort),
    .next_table(next_table), .syndrome(syndrome), .fault_addr(fault_addr)
  );

  // 0 = low half, 1 = high half, 2 = refused
  function automatic int half_of(input logic [63:0] va);
    if ((va >> 48) == 64'd0)      return 0;
    if ((va >> 48) == 64'hFFFF)   return 1;
    return 2;
  endfunction

  function automatic logic [47:0] exp_daddr(input logic [63:0] base,
                                            input logic [63:0] va);
    logic [63:0] a;
    a = (base & 64'h0000_FFFF_FFFF_F000) | (((va >> 39) & 64'h1FF) << 3);
    return a[47:0];
  endfunction

  function automatic logic [31:0] exp_syn(input logic w);
    return 32'h9600_0004 | (w ? 32'h40 : 32'h0);
  endfunction

  function automatic logic [47:0] exp_next(input logic [63:0] d);
    logic [63:0] a;
    a = d & 64'h0000_FFFF_FFFF_F000;
    return a[47:0];
  endfunction

  task automatic check(input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_walk(input logic [63:0] va, input logic w,
                          input logic [63:0] lo, input logic [63:0] hi,
                          input logic [63:0] desc, input int lat,
                          input bit poke);
    int h;
    h = half_of(va);
    @(negedge clk);
    base_lo = lo; base_hi = hi;
    req_va = va; req_write = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (h == 2) begin
      check("R4 no read on refused address", {63'd0, mem_req}, 64'd0);
      check("R4 done after refusal", {62'd0, done, abort}, 64'd3);
      check("R7 syndrome on refusal", {32'd0, syndrome}, {32'd0, exp_syn(w)});
      check("R8 fault address on refusal", fault_addr, va);
    end else begin
      check("R3 read issued", {63'd0, mem_req}, 64'd1);
      check("R2 descriptor address", {16'd0, mem_addr},
            {16'd0, exp_daddr(h == 1 ? hi : lo, va)});
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        check("R3 single read pulse", {63'd0, mem_req}, 64'd0);
        if (poke) begin
          req_valid = 1'b1; req_va = ~va; req_write = ~w;
        end
      end
      req_valid = 1'b0;
      mem_rvalid = 1'b1; mem_rdata = desc;
      @(negedge clk);
      mem_rvalid = 1'b0;
      check("R11 done after response", {63'd0, done}, 64'd1);
      if (desc[1:0] == 2'b11) begin
        check("R5 table outcome", {62'd0, ok, abort}, 64'd2);
        check("R5 next table address", {16'd0, next_table}, {16'd0, exp_next(desc)});
      end else begin
        check("R6 fault outcome", {62'd0, ok, abort}, 64'd1);
        check("R7 syndrome", {32'd0, syndrome}, {32'd0, exp_syn(w)});
        check(poke ? "R9 fault address kept" : "R8 fault address", fault_addr, va);
      end
    end
    @(negedge clk);
    check("R11 done is a pulse", {61'd0, done, ok, abort}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] va, d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset state", {59'd0, busy, done, ok, abort, mem_req}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {59'd0, busy, done, ok, abort, mem_req}, 64'd0);

    // R10: stray responses while idle
    mem_rvalid = 1'b1; mem_rdata = 64'h3;
    @(negedge clk);
    @(negedge clk);
    mem_rvalid = 1'b0;
    check("R10 stray response ignored", {62'd0, done, busy}, 64'd0);

    // Directed: high-half store fault at index 2
    run_walk(64'hFFFF_0100_0000_0000, 1'b1, 64'h0, 64'h8200_0000,
             64'h0, 2, 1'b0);
    check("R7 store syndrome 0x96000044", {32'd0, syndrome}, 64'h9600_0044);
    // Directed: low-half table hit, load
    run_walk(64'h0000_7F80_0000_1234, 1'b0, 64'h1234_5678_9ABC_DFFF, 64'h0,
             64'hFFFF_ABCD_1234_5FFB, 1, 1'b0);
    // Directed: refused address
    run_walk(64'h0001_0000_0000_0000, 1'b0, 64'h0, 64'h0, 64'h0, 1, 1'b0);
    run_walk(64'hFFFE_FFFF_FFFF_FFFF, 1'b1, 64'h0, 64'h0, 64'h0, 1, 1'b0);
    // Directed: level-0 block-type descriptor faults, load
    run_walk(64'h0000_0000_0000_0040, 1'b0, 64'h4000, 64'h0, 64'h8001, 3, 1'b0);
    check("R7 load syndrome 0x96000004", {32'd0, syndrome}, 64'h9600_0004);
    // Directed: requests pushed mid-walk are dropped
    run_walk(64'hFFFF_8000_0000_0000, 1'b1, 64'h0, 64'hABC000, 64'h2, 3, 1'b1);
    run_walk(64'h0000_0080_0000_0000, 1'b0, 64'h5000, 64'h0, 64'h7000_0003, 2, 1'b1);

    for (int k = 0; k < 300; k++) begin
      int cls;
      cls = $urandom_range(0, 2);
      va = {$urandom(), $urandom()};
      if (cls == 0) va[63:48] = 16'h0000;
      else if (cls == 1) va[63:48] = 16'hFFFF;
      else if (va[63:48] == 16'h0000 || va[63:48] == 16'hFFFF) va[63:48] = 16'h00F0;
      d = {$urandom(), $urandom()};
      run_walk(va, 1'($urandom()), {$urandom(), $urandom()},
               {$urandom(), $urandom()}, d, $urandom_range(1, 4),
               1'($urandom_range(0, 3) == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule